// File: doc/BRIEF.md
# Power Converter Soft-Start Sequencer

This block steps a digitally regulated power supply through its start-up and shut-down life cycle. It produces a reference that climbs from zero to the target output voltage. It also selects which loop filter the compensator uses, controls the power-stage enable and produces a debounced power-good output. The compensator, the converters that measure the output and the fault response policies sit outside the block. It sees them only as a filter-select line, a "voltage in window" input and a vector of raw fault flags.

Time is counted in millisecond ticks from a shared tick strobe. After enable rises and no raw fault is present, the block waits a turn-on delay. It then ramps the reference over a rise time while the soft-start filter is selected. Next comes an optional settling interval of 5 or 10 ticks, and after that the normal filter takes over. Power-good follows once its own rising debounce expires. Fault flags can be masked one by one during the ramp only. An unmasked fault after the turn-on delay latches the block off until enable is cycled. A software restart strobe drops the stage at once and restarts the whole sequence after one of four delays. Releasing enable shuts the stage down either at once or after a turn-off delay.

Top module: `softstart_seq`

## Requirements
- R1: With `en_req` high and `flt_raw` all zero in the idle state, `stage_en` rises exactly `ton_delay` ticks later. While any `flt_raw` bit is set, the block does not leave idle.
- R2: `vref` is 0 when `stage_en` rises. After k ticks of ramp, `vref` equals floor(`vset`·k/`ton_rise`) and reaches exactly `vset` after `ton_rise` ticks. With `ton_rise` = 0 it reaches `vset` one cycle after the ramp starts, and it never exceeds `vset`.
- R3: At the end of the ramp, `filt_norm` rises after 5 ticks (`settle_long`=0) or 10 ticks (`settle_long`=1) if `settle_en`=1. If `settle_en`=0 it rises at once.
- R4: `ss_flag` is high for the whole ramp and the settling interval, and low once `filt_norm` is high.
- R5: After `filt_norm` rises with `vout_ok` high and no fault, `pgood` rises `pg_on_dly` ticks later. It never rises while the normal filter is not selected.
- R6: During the ramp, `flt_out` = `flt_raw` & ~`flt_blank`. Outside the ramp, `flt_out` = `flt_raw`.
- R7: In steady state, `pgood` falls `pg_off_dly` ticks after `vout_ok` goes low. A low spell shorter than that leaves `pgood` high. `pgood` is never high while `stage_en` is low.
- R8: A `swrst` pulse while the stage is enabled drops `stage_en` on the next cycle. `stage_en` rises again after the restart delay plus `ton_delay` ticks, where `rst_sel` 00/01/10/11 selects 0/500/1000/2000 ticks.
- R9: When `ton_delay` = 0 and `rst_sel` = 00, a `swrst` pulse has no effect: the stage stays on, `filt_norm` stays high and `vref` holds `vset`.
- R10: When `en_req` falls with `off_delayed`=0, `stage_en` drops on the next cycle. With `off_delayed`=1, `stage_en` stays high for `toff_delay` ticks and `pgood` drops at once.
- R11: An unmasked fault (any `flt_out` bit) while `stage_en` is high drops `stage_en` and `pgood` on the next cycle. The block then stays off, even after the fault clears, until `en_req` goes low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| en_req | input | 1 | Supply on request |
| ton_delay | input | W_TIME | Turn-on delay in ticks |
| ton_rise | input | W_TIME | Ramp duration in ticks |
| toff_delay | input | W_TIME | Turn-off delay in ticks |
| off_delayed | input | 1 | 1 = delayed shutdown, 0 = immediate |
| vset | input | W_REF | Output voltage setpoint |
| settle_en | input | 1 | Enable settling interval after the ramp |
| settle_long | input | 1 | Settling interval: 0 = 5 ticks, 1 = 10 ticks |
| pg_on_dly | input | W_TIME | Power-good rising debounce in ticks |
| pg_off_dly | input | W_TIME | Power-good falling debounce in ticks |
| vout_ok | input | 1 | Output voltage within the good window |
| flt_raw | input | N_FLT | Raw fault flags |
| flt_blank | input | N_FLT | Per-flag mask applied during the ramp |
| swrst | input | 1 | Software restart strobe |
| rst_sel | input | 2 | Restart delay code |
| vref | output | W_REF | Ramping reference |
| filt_norm | output | 1 | 1 = normal loop filter selected |
| ss_flag | output | 1 | Soft-start filter in use |
| pgood | output | 1 | Debounced power-good |
| stage_en | output | 1 | Power-stage enable |
| flt_out | output | N_FLT | Fault flags after masking |

## Verification
The assertions check the cycle-level rules on every cycle. A fault or an accepted restart strobe turns the stage off on the next cycle. Power-good implies an enabled stage and only rises under the normal filter. Each ramp starts from zero, never overshoots and never steps downward. Nothing leaves idle while a raw fault is present. The exact tick counts need the bench's scenarios: the turn-on, rise, settling, debounce, turn-off and restart durations. So do the exact ramp values at every tick, compared against floor(vset·k/rise), the fault latch that holds until enable is cycled, and the ignored restart strobe.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TON,
        ST_RAMP,
        ST_SETTLE,
        ST_RUN,
        ST_TOFF,
        ST_RSTW,
        ST_TRIP
    } ssq_state_e;
endpackage

// File: rtl/ssq_ramp.sv
// Reference ramp: per-tick step of setpt/rise with a remainder accumulator.
module ssq_ramp #(
    parameter int W_REF  = 12,
    parameter int W_TIME = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic              load,
    input  logic [W_REF-1:0]  setpt,
    input  logic [W_TIME-1:0] rise,
    output logic [W_REF-1:0]  vref
);
    localparam int W_OP  = (W_REF > W_TIME) ? W_REF : W_TIME;
    localparam int W_SUM = W_REF + 1;

    typedef struct packed {
        logic [W_REF-1:0]  v;
        logic [W_TIME-1:0] err;
    } ramp_t;

    ramp_t r_d, r_q;
    logic [W_OP-1:0]   num_e, den_e, quo_e, rem_e;
    logic [W_TIME:0]   esum;
    logic              carry;
    logic [W_SUM-1:0]  vsum;

    always_comb begin
        num_e = W_OP'(setpt);
        den_e = (rise == '0) ? W_OP'(1) : W_OP'(rise);
        quo_e = num_e / den_e;
        rem_e = num_e % den_e;
        esum  = {1'b0, r_q.err} + {1'b0, rem_e[W_TIME-1:0]};
        carry = (esum >= {1'b0, rise});
        vsum  = {1'b0, r_q.v} + {1'b0, quo_e[W_REF-1:0]} + W_SUM'(carry);
        r_d   = r_q;
        if (clr) begin
            r_d = '0;
        end else if (load) begin
            r_d.v   = setpt;
            r_d.err = '0;
        end else if (adv) begin
            r_d.err = carry ? W_TIME'(esum - {1'b0, rise}) : esum[W_TIME-1:0];
            r_d.v   = (vsum >= {1'b0, setpt}) ? setpt : vsum[W_REF-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vref = r_q.v;

    // R2: a ramp step never carries the reference past the setpoint
    a_r2_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (vref <= $past(setpt)));
endmodule

// File: rtl/ssq_pgdeb.sv
// Power-good debounce with separate rising and falling windows.
module ssq_pgdeb #(
    parameter int W_TIME = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              arm,
    input  logic              good,
    input  logic [W_TIME-1:0] on_dly,
    input  logic [W_TIME-1:0] off_dly,
    output logic              pg
);
    typedef struct packed {
        logic              pg;
        logic [W_TIME-1:0] cnt;
    } pg_t;

    pg_t p_d, p_q;
    logic [W_TIME-1:0] lim;
    logic              want;

    always_comb begin
        lim  = p_q.pg ? off_dly : on_dly;
        want = p_q.pg ? !good : good;
        p_d  = p_q;
        if (!arm) begin
            p_d = '0;
        end else if (!want) begin
            p_d.cnt = '0;
        end else if (p_q.cnt >= lim) begin
            p_d.pg  = !p_q.pg;
            p_d.cnt = '0;
        end else if (tick) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pg = p_q.pg;

    // R5: power-good only rises on a cycle where the good condition held
    a_r5_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> $past(good));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ssq_pkg::*;
#(
    parameter int W_REF        = 12,
    parameter int W_TIME       = 12,
    parameter int N_FLT        = 4,
    parameter int SETTLE_SHORT = 5,
    parameter int SETTLE_LONG  = 10,
    parameter int RST_UNIT_MS  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              en_req,
    input  logic [W_TIME-1:0] ton_delay,
    input  logic [W_TIME-1:0] ton_rise,
    input  logic [W_TIME-1:0] toff_delay,
    input  logic              off_delayed,
    input  logic [W_REF-1:0]  vset,
    input  logic              settle_en,
    input  logic              settle_long,
    input  logic [W_TIME-1:0] pg_on_dly,
    input  logic [W_TIME-1:0] pg_off_dly,
    input  logic              vout_ok,
    input  logic [N_FLT-1:0]  flt_raw,
    input  logic [N_FLT-1:0]  flt_blank,
    input  logic              swrst,
    input  logic [1:0]        rst_sel,
    output logic [W_REF-1:0]  vref,
    output logic              filt_norm,
    output logic              ss_flag,
    output logic              pgood,
    output logic              stage_en,
    output logic [N_FLT-1:0]  flt_out
);
    localparam int W_RST  = $clog2(4 * RST_UNIT_MS + SETTLE_LONG + 1);
    localparam int W_CNT  = (W_TIME > W_RST) ? W_TIME : W_RST;
    localparam logic [W_CNT-1:0] RL_1 = W_CNT'(RST_UNIT_MS);
    localparam logic [W_CNT-1:0] RL_2 = W_CNT'(2 * RST_UNIT_MS);
    localparam logic [W_CNT-1:0] RL_3 = W_CNT'(4 * RST_UNIT_MS);

    typedef struct packed {
        ssq_state_e       st;
        logic [W_CNT-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [N_FLT-1:0] blank_mask, gated;
    logic             trip, swr_ok, done, on_stage;
    logic [W_CNT-1:0] lim, rst_lim;
    ssq_state_e       nxt;

    always_comb begin
        blank_mask = (s_q.st == ST_RAMP) ? flt_blank : '0;
        gated      = flt_raw & ~blank_mask;
        trip       = |gated;
        swr_ok     = swrst && !((ton_delay == '0) && (rst_sel == 2'b00));
        case (rst_sel)
            2'b00:   rst_lim = '0;
            2'b01:   rst_lim = RL_1;
            2'b10:   rst_lim = RL_2;
            default: rst_lim = RL_3;
        endcase
        case (s_q.st)
            ST_TON:    lim = W_CNT'(ton_delay);
            ST_RAMP:   lim = W_CNT'(ton_rise);
            ST_SETTLE: lim = settle_long ? W_CNT'(SETTLE_LONG) : W_CNT'(SETTLE_SHORT);
            ST_TOFF:   lim = W_CNT'(toff_delay);
            ST_RSTW:   lim = rst_lim;
            default:   lim = '0;
        endcase
        done = (s_q.cnt >= lim);

        nxt = s_q.st;
        case (s_q.st)
            ST_IDLE:
                if (en_req && !(|flt_raw)) nxt = ST_TON;
            ST_TON:
                if (!en_req)     nxt = ST_IDLE;
                else if (swr_ok) nxt = ST_RSTW;
                else if (done)   nxt = ST_RAMP;
            ST_RAMP, ST_SETTLE, ST_RUN:
                if (trip)         nxt = ST_TRIP;
                else if (swr_ok)  nxt = ST_RSTW;
                else if (!en_req) nxt = off_delayed ? ST_TOFF : ST_IDLE;
                else if (s_q.st == ST_RAMP && done)
                    nxt = settle_en ? ST_SETTLE : ST_RUN;
                else if (s_q.st == ST_SETTLE && done)
                    nxt = ST_RUN;
            ST_TOFF:
                if (trip)        nxt = ST_TRIP;
                else if (swr_ok) nxt = ST_RSTW;
                else if (done)   nxt = ST_IDLE;
            ST_RSTW:
                if (!en_req)   nxt = ST_IDLE;
                else if (done) nxt = ST_TON;
            ST_TRIP:
                if (!en_req) nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase

        s_d.st  = nxt;
        if (nxt != s_q.st)                s_d.cnt = '0;
        else if (tick_ms && s_q.cnt != '1) s_d.cnt = s_q.cnt + 1'b1;
        else                              s_d.cnt = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    ssq_ramp #(.W_REF(W_REF), .W_TIME(W_TIME)) ramp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (s_q.st == ST_IDLE || s_q.st == ST_TON ||
                s_q.st == ST_RSTW || s_q.st == ST_TRIP),
        .adv   (tick_ms && s_q.st == ST_RAMP),
        .load  (s_q.st == ST_RAMP && ton_rise == '0),
        .setpt (vset),
        .rise  (ton_rise),
        .vref  (vref)
    );

    ssq_pgdeb #(.W_TIME(W_TIME)) pgdeb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .arm     (s_d.st == ST_RUN),
        .good    (vout_ok && !trip),
        .on_dly  (pg_on_dly),
        .off_dly (pg_off_dly),
        .pg      (pgood)
    );

    assign on_stage  = (s_q.st == ST_RAMP) || (s_q.st == ST_SETTLE) ||
                       (s_q.st == ST_RUN)  || (s_q.st == ST_TOFF);
    assign stage_en  = on_stage;
    assign ss_flag   = (s_q.st == ST_RAMP) || (s_q.st == ST_SETTLE);
    assign filt_norm = (s_q.st == ST_RUN)  || (s_q.st == ST_TOFF);
    assign flt_out   = gated;

    // R1: a raw fault in idle keeps the stage off
    a_r1_no_start_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && |flt_raw) |=> !stage_en);
    // R2: every ramp begins from a zero reference
    a_r2_ramp_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_en) |-> (vref == '0));
    // R2: the reference never steps down while ramping
    a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RAMP && $past(s_q.st) == ST_RAMP && $stable(vset))
            |-> (vref >= $past(vref)));
    // R5: power-good rises only under the normal filter
    a_r5_pg_after_handover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> filt_norm);
    // R7: power-good implies an enabled stage
    a_r7_pg_needs_stage: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> stage_en);
    // R8: an accepted restart strobe drops the stage next cycle
    a_r8_swrst_drops_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst && stage_en && !(ton_delay == '0 && rst_sel == 2'b00) && !(|flt_out))
            |=> !stage_en);
    // R11: an unmasked fault drops the stage next cycle
    a_r11_fault_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en && |flt_out) |=> (!stage_en && !pgood));
endmodule

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  div = '0;
    logic        en_req = 1'b0;
    logic [11:0] ton_delay = '0, ton_rise = '0, toff_delay = '0;
    logic        off_delayed = 1'b0;
    logic [11:0] vset = '0;
    logic        settle_en = 1'b0, settle_long = 1'b0;
    logic [11:0] pg_on_dly = '0, pg_off_dly = '0;
    logic        vout_ok = 1'b1;
    logic [3:0]  flt_raw = '0, flt_blank = '0;
    logic        swrst = 1'b0;
    logic [1:0]  rst_sel = '0;
    logic [11:0] vref;
    logic        filt_norm, ss_flag, pgood, stage_en;
    logic [3:0]  flt_out;

    int n_chk = 0, n_fail = 0, tick_cnt = 0;
    bit ended = 0;

    always #2 clk = ~clk;   // 250 MHz

    always @(negedge clk) begin
        div  <= div + 1'b1;
        tick <= (div == 3'd7);
    end
    always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

    softstart_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick), .en_req(en_req),
        .ton_delay(ton_delay), .ton_rise(ton_rise), .toff_delay(toff_delay),
        .off_delayed(off_delayed), .vset(vset), .settle_en(settle_en),
        .settle_long(settle_long), .pg_on_dly(pg_on_dly), .pg_off_dly(pg_off_dly),
        .vout_ok(vout_ok), .flt_raw(flt_raw), .flt_blank(flt_blank),
        .swrst(swrst), .rst_sel(rst_sel), .vref(vref), .filt_norm(filt_norm),
        .ss_flag(ss_flag), .pgood(pgood), .stage_en(stage_en), .flt_out(flt_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int w);
        case (w)
            0:       return stage_en;
            1:       return filt_norm;
            default: return pgood;
        endcase
    endfunction

    task automatic sync_tick();
        @(posedge clk iff tick);
        @(negedge clk);
    endtask

    task automatic wait_lvl(input int w, input logic lvl, input int t0, output int n);
        n = -1;
        for (int i = 0; i < 40000; i++) begin
            if (sig(w) == lvl) begin
                n = tick_cnt - t0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        off_delayed = 1'b0;
        en_req = 1'b0;
        cycles(3);
    endtask

    // Full start-up: returns with the supply running and power-good high
    task automatic start_seq(input int ton, input int rise, input int vs,
                             input int smode, input int ondly);
        int t0, n, st;
        ton_delay = 12'(ton); ton_rise = 12'(rise); vset = 12'(vs);
        settle_en = (smode != 0); settle_long = (smode == 2);
        pg_on_dly = 12'(ondly);
        st = (smode == 0) ? 0 : (smode == 1) ? 5 : 10;
        sync_tick();
        en_req = 1'b1;
        t0 = tick_cnt;
        wait_lvl(0, 1'b1, t0, n);
        chk("R1 turn-on delay", n, ton);
        chk("R2 ramp starts at zero", vref, 0);
        chk("R4 soft-start flag in ramp", ss_flag, 1);
        wait_lvl(1, 1'b1, t0, n);
        chk("R3 filter handover time", n, ton + rise + st);
        chk("R4 soft-start flag cleared", ss_flag, 0);
        chk("R2 ramp ends at setpoint", vref, vs);
        wait_lvl(2, 1'b1, t0, n);
        chk("R5 power-good debounce", n, ton + rise + st + ondly);
    endtask

    initial begin
        int n, t0;
        int tons[2]  = '{0, 3};
        int rises[3] = '{0, 1, 7};
        int idx = 0;
        cycles(4);
        chk("R1 reset stage_en", stage_en, 0);
        chk("R5 reset pgood", pgood, 0);
        chk("R4 reset ss_flag", ss_flag, 0);
        chk("R3 reset filt_norm", filt_norm, 0);
        chk("R2 reset vref", vref, 0);
        rst_n = 1'b1;
        cycles(3);

        // Sweep of start-up timing
        foreach (tons[a]) foreach (rises[b])
            for (int sm = 0; sm < 3; sm++)
                for (int od = 0; od < 4; od += 2) begin
                    start_seq(tons[a], rises[b], (idx == 5) ? 4095 : 100 + 37 * idx, sm, od);
                    idx++;
                    go_idle();
                    chk("R10 immediate shutdown", stage_en, 0);
                end

        // Exact ramp values, r2_values
        for (int ri = 0; ri < 4; ri++)
            for (int vi = 0; vi < 4; vi++) begin
                int rs, vs;
                rs = (ri == 0) ? 1 : (ri == 1) ? 3 : (ri == 2) ? 7 : 13;
                vs = (vi == 0) ? 5 : (vi == 1) ? 1000 : (vi == 2) ? 4095 : 0;
                ton_delay = 12'd1; ton_rise = 12'(rs); vset = 12'(vs);
                settle_en = 1'b0;
                sync_tick();
                en_req = 1'b1;
                wait_lvl(0, 1'b1, tick_cnt, n);
                for (int k = 1; k <= rs; k++) begin
                    sync_tick();
                    chk("R2 ramp value", vref, (vs * k) / rs);
                end
                go_idle();
            end

        // R1: raw fault at enable blocks start
        flt_raw = 4'b0100;
        ton_delay = 12'd2; ton_rise = 12'd2; settle_en = 1'b0; pg_on_dly = '0;
        sync_tick();
        en_req = 1'b1;
        repeat (5) sync_tick();
        chk("R1 no start under fault", stage_en, 0);
        sync_tick();
        flt_raw = '0;
        t0 = tick_cnt;
        wait_lvl(0, 1'b1, t0, n);
        chk("R1 start after fault clears", n, 2);
        go_idle();

        // R6 / R11: masked fault during ramp, trips at ramp end
        flt_blank = 4'b0001;
        ton_delay = 12'd2; ton_rise = 12'd7; settle_en = 1'b1; settle_long = 1'b0;
        sync_tick();
        en_req = 1'b1;
        t0 = tick_cnt;
        wait_lvl(0, 1'b1, t0, n);
        flt_raw = 4'b0001;
        #1;
        chk("R6 masked flag hidden in ramp", flt_out, 0);
        sync_tick();
        chk("R6 masked fault keeps stage on", stage_en, 1);
        wait_lvl(0, 1'b0, t0, n);
        chk("R6 mask ends with ramp", n, 9);
        chk("R6 flag visible after ramp", flt_out, 4'b0001);
        flt_raw = '0;
        repeat (3) sync_tick();
        chk("R11 latched off until enable cycles", stage_en, 0);
        go_idle();

        // R6: unmasked flag in ramp trips at once
        sync_tick();
        en_req = 1'b1;
        wait_lvl(0, 1'b1, tick_cnt, n);
        flt_raw = 4'b0100;
        #1;
        chk("R6 unmasked flag passes in ramp", flt_out, 4'b0100);
        cycles(1);
        chk("R11 ramp fault drops stage", stage_en, 0);
        flt_raw = '0;
        go_idle();
        flt_blank = '0;

        // R11: fault in steady state, then restart by enable cycle
        start_seq(1, 3, 2000, 0, 1);
        flt_raw = 4'b0010;
        cycles(1);
        chk("R11 run fault drops stage", stage_en, 0);
        chk("R11 run fault drops pgood", pgood, 0);
        flt_raw = '0;
        repeat (3) sync_tick();
        chk("R11 stays off with enable held", stage_en, 0);
        go_idle();
        start_seq(1, 3, 2000, 0, 1);

        // R7: falling debounce and short glitch
        pg_off_dly = 12'd3;
        sync_tick();
        vout_ok = 1'b0;
        repeat (2) @(posedge clk iff tick);
        @(negedge clk);
        vout_ok = 1'b1;
        cycles(20);
        chk("R7 short glitch keeps pgood", pgood, 1);
        sync_tick();
        vout_ok = 1'b0;
        t0 = tick_cnt;
        wait_lvl(2, 1'b0, t0, n);
        chk("R7 falling debounce", n, 3);
        sync_tick();
        vout_ok = 1'b1;
        t0 = tick_cnt;
        wait_lvl(2, 1'b1, t0, n);
        chk("R7 power-good returns after rising debounce", n, 1);
        go_idle();

        // R8: restart delays for every code
        for (int c = 0; c < 4; c++) begin
            int exp_d;
            exp_d = (c == 0) ? 0 : (c == 1) ? 500 : (c == 2) ? 1000 : 2000;
            start_seq(2, 1, 300, 0, 0);
            rst_sel = 2'(c);
            sync_tick();
            swrst = 1'b1;
            t0 = tick_cnt;
            cycles(1);
            swrst = 1'b0;
            chk("R8 restart drops stage", stage_en, 0);
            wait_lvl(0, 1'b1, t0, n);
            chk("R8 restart delay", n, exp_d + 2);
            go_idle();
        end

        // R9: restart strobe ignored with both delays zero
        rst_sel = 2'b00;
        start_seq(0, 2, 777, 0, 0);
        sync_tick();
        swrst = 1'b1;
        cycles(1);
        swrst = 1'b0;
        cycles(3);
        chk("R9 ignored strobe keeps stage", stage_en, 1);
        chk("R9 ignored strobe keeps filter", filt_norm, 1);
        chk("R9 ignored strobe keeps vref", vref, 777);
        go_idle();

        // R10: delayed shutdown
        start_seq(1, 2, 500, 1, 2);
        toff_delay = 12'd3;
        off_delayed = 1'b1;
        sync_tick();
        en_req = 1'b0;
        t0 = tick_cnt;
        cycles(2);
        chk("R10 stage held during turn-off delay", stage_en, 1);
        chk("R10 pgood drops at shutdown start", pgood, 0);
        wait_lvl(0, 1'b0, t0, n);
        chk("R10 turn-off delay", n, 3);
        off_delayed = 1'b0;
        cycles(3);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule